// File: doc/BRIEF.md
# Interrupt Entry Sequencer

This block carries out the hardware part of taking an interrupt in a small 8-bit microcontroller core. It keeps a latched reset request and a vector of pending interrupt source bits. It decides when an interrupt may be taken, based on the global interrupt-enable flag and on a flag meaning that the next instruction is to be skipped. When it takes an interrupt, it saves the return word address on the data stack through a byte-wide write port. It then gives the core a new program counter, a new stack pointer and a request to clear the global enable.

The core owns the program counter, the stack pointer and the enable flag. The sequencer reads them and sends back load pulses. It asserts `busy` from the first stack write through the program-counter load, and the core stalls fetch for that whole time. Two configuration inputs select how many return bytes are pushed (1, 2 or 3) and whether vector slots are one or two words wide.

The controller has three states. `ST_IDLE` waits for acceptance. `ST_PUSH` writes one return byte per cycle. `ST_LOAD` issues the program-counter, stack-pointer and enable-clear pulses. The transitions are ACCEPT (`ST_IDLE` to `ST_PUSH`), STEP (`ST_PUSH` stays in `ST_PUSH` while bytes remain), LAST (`ST_PUSH` to `ST_LOAD` after the final byte) and DONE (`ST_LOAD` to `ST_IDLE`).

Top module: `irq_entry_seq`

## Requirements
- R1: No acceptance of any kind, reset request included, takes place in a cycle where `skip_pend` is 1. `busy` stays 0 while the sequencer is idle and `skip_pend` is held high.
- R2: Acceptance requires `gie` = 1. With `gie` = 0, pending reset or source bits leave `busy` at 0 and `irq_req` at 1.
- R3: A latched reset request (set by a one-cycle pulse on `reset_req`) wins over all pending source bits and uses vector number 0. Taking it clears no source bit.
- R4: Among the pending source bits, the lowest set index n is serviced, with vector number n+1.
- R5: `pc_new` equals the vector number times the slot size, with a base of 0. The slot size is 2 words when `cfg_long_vec` = 1 and 1 word when it is 0.
- R6: The return address is pushed low byte first, then the middle byte, then the high byte. The byte count is `cfg_pc_bytes`: 2'd1, 2'd2 or 2'd3, with 2'd0 treated as 1. Byte k is written at address `sp_cur` − k. `sp_next` equals `sp_cur` minus the byte count.
- R7: Exactly one byte is written per cycle on consecutive cycles. `busy` is high for exactly the byte count plus one cycles, starting on the cycle after acceptance.
- R8: In the final busy cycle, `pc_load`, `sp_load` and `gie_clr` are all 1 and no stack write takes place. `busy` is 0 in the next cycle.
- R9: Accepting a source interrupt clears only that source's bit in `pend_q`. `irq_req` stays 1 while any bit or the reset request remains pending.
- R10: A `src_set` pulse that arrives during an entry sequence is kept in `pend_q` and is taken at the next acceptance point.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reset_req | input | 1 | One-cycle pulse that latches a reset request |
| src_set | input | NSRC | One-cycle pulses that set pending source bits |
| gie | input | 1 | Global interrupt-enable flag from the core |
| skip_pend | input | 1 | Next instruction is to be skipped |
| cfg_pc_bytes | input | 2 | Return bytes to push (0 treated as 1) |
| cfg_long_vec | input | 1 | 1: two-word vector slots |
| ret_pc | input | PCW | Word address of the next instruction |
| sp_cur | input | SPW | Current stack pointer |
| busy | output | 1 | Entry sequence in progress (fetch stall) |
| irq_req | output | 1 | Something is pending |
| pend_q | output | NSRC | Pending source bits |
| mem_we | output | 1 | Stack byte write strobe |
| mem_addr | output | SPW | Stack byte write address |
| mem_wdata | output | 8 | Stack byte write data |
| pc_load | output | 1 | Load `pc_new` into the program counter |
| pc_new | output | PCW | Vector address |
| sp_load | output | 1 | Load `sp_next` into the stack pointer |
| sp_next | output | SPW | Stack pointer after the push |
| gie_clr | output | 1 | Clear the global interrupt enable |

## Verification
The assertions assume that the core honours `gie_clr` by dropping `gie` by the next cycle, and that `sp_cur`, `ret_pc` and the configuration inputs do not change while `busy` is high. They also assume that `sp_cur` is at least the byte count, so the address step never wraps. The bench models the enable flag as a register that clears on `gie_clr` and sets only on an explicit request. It changes the configuration, return address and stack pointer only while the sequencer is idle. The stack pointers it uses sit far above zero.

// File: rtl/irq_entry_pkg.sv
package irq_entry_pkg;
    localparam int BYTE_W   = 8;
    localparam int MAX_PUSH = 3;
    localparam int RET_W    = BYTE_W * MAX_PUSH;

    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_PUSH = 2'd1,
        ST_LOAD = 2'd2
    } entry_state_t;
endpackage

// File: rtl/irq_lsb_pick.sv
module irq_lsb_pick #(
    parameter int N  = 8,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic [N-1:0]  req,
    output logic          found,
    output logic [N-1:0]  onehot,
    output logic [IW-1:0] idx
);
    logic [N:0] seen;
    assign seen[0] = 1'b0;

    for (genvar gi = 0; gi < N; gi++) begin : g_chain
        assign onehot[gi]   = req[gi] & ~seen[gi];
        assign seen[gi + 1] = seen[gi] | req[gi];
    end

    assign found = seen[N];

    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (onehot[i]) idx = idx | IW'(i);
        end
    end
endmodule

// File: rtl/irq_vec_calc.sv
module irq_vec_calc #(
    parameter int IW  = 3,
    parameter int PCW = 22
) (
    input  logic           take_rst,
    input  logic [IW-1:0]  src_idx,
    input  logic           long_slot,
    output logic [PCW-1:0] vec_pc
);
    localparam int VW = IW + 1;
    logic [VW-1:0] vec_num;

    always_comb begin
        if (take_rst) vec_num = '0;
        else          vec_num = VW'(src_idx) + VW'(1);
        vec_pc = PCW'(vec_num) << long_slot;
    end
endmodule

// File: rtl/irq_push_mux.sv
module irq_push_mux
    import irq_entry_pkg::*;
(
    input  logic [RET_W-1:0]  ret_word,
    input  logic [1:0]        sel,
    output logic [BYTE_W-1:0] byte_out
);
    logic [BYTE_W-1:0] lanes [MAX_PUSH];

    for (genvar gk = 0; gk < MAX_PUSH; gk++) begin : g_lane
        assign lanes[gk] = ret_word[gk*BYTE_W +: BYTE_W];
    end

    always_comb begin
        byte_out = lanes[0];
        for (int k = 0; k < MAX_PUSH; k++) begin
            if (sel == 2'(k)) byte_out = lanes[k];
        end
    end
endmodule

// File: rtl/irq_entry_seq.sv
module irq_entry_seq
    import irq_entry_pkg::*;
#(
    parameter int NSRC = 8,
    parameter int PCW  = 22,
    parameter int SPW  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reset_req,
    input  logic [NSRC-1:0]   src_set,
    input  logic              gie,
    input  logic              skip_pend,
    input  logic [1:0]        cfg_pc_bytes,
    input  logic              cfg_long_vec,
    input  logic [PCW-1:0]    ret_pc,
    input  logic [SPW-1:0]    sp_cur,
    output logic              busy,
    output logic              irq_req,
    output logic [NSRC-1:0]   pend_q,
    output logic              mem_we,
    output logic [SPW-1:0]    mem_addr,
    output logic [BYTE_W-1:0] mem_wdata,
    output logic              pc_load,
    output logic [PCW-1:0]    pc_new,
    output logic              sp_load,
    output logic [SPW-1:0]    sp_next,
    output logic              gie_clr
);
    localparam int IW = (NSRC > 1) ? $clog2(NSRC) : 1;

    entry_state_t      state, state_nx;
    logic [NSRC-1:0]   pend_r;
    logic              rst_pend;
    logic [RET_W-1:0]  ret_r;
    logic [SPW-1:0]    sp_r;
    logic [PCW-1:0]    vec_pc_r;
    logic [1:0]        bidx;
    logic [1:0]        nbytes_r;

    logic              src_found;
    logic [NSRC-1:0]   src_onehot;
    logic [IW-1:0]     src_idx;
    logic [PCW-1:0]    vec_pc;
    logic [BYTE_W-1:0] push_byte;
    logic              accept;
    logic              last_byte;
    logic [1:0]        nbytes_cfg;
    logic [NSRC-1:0]   clr_mask;

    irq_lsb_pick #(.N(NSRC)) u_pick (
        .req    (pend_r),
        .found  (src_found),
        .onehot (src_onehot),
        .idx    (src_idx)
    );

    irq_vec_calc #(.IW(IW), .PCW(PCW)) u_vec (
        .take_rst  (rst_pend),
        .src_idx   (src_idx),
        .long_slot (cfg_long_vec),
        .vec_pc    (vec_pc)
    );

    irq_push_mux u_mux (
        .ret_word (ret_r),
        .sel      (bidx),
        .byte_out (push_byte)
    );

    assign accept     = (state == ST_IDLE) && !skip_pend && gie && (rst_pend || src_found);
    assign nbytes_cfg = (cfg_pc_bytes == 2'd0) ? 2'd1 : cfg_pc_bytes;
    assign last_byte  = (bidx == nbytes_r - 2'd1);
    assign clr_mask   = (accept && !rst_pend) ? src_onehot : '0;

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    // Transitions: ACCEPT, STEP, LAST, DONE
    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE: if (accept)    state_nx = ST_PUSH;
            ST_PUSH: if (last_byte) state_nx = ST_LOAD;
            ST_LOAD:                state_nx = ST_IDLE;
            default:                state_nx = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        busy      = 1'b0;
        mem_we    = 1'b0;
        pc_load   = 1'b0;
        sp_load   = 1'b0;
        gie_clr   = 1'b0;
        unique case (state)
            ST_IDLE: ;
            ST_PUSH: begin
                busy   = 1'b1;
                mem_we = 1'b1;
            end
            ST_LOAD: begin
                busy    = 1'b1;
                pc_load = 1'b1;
                sp_load = 1'b1;
                gie_clr = 1'b1;
            end
            default: ;
        endcase
    end

    assign mem_addr  = sp_r;
    assign mem_wdata = push_byte;
    assign pc_new    = vec_pc_r;
    assign sp_next   = sp_r;
    assign pend_q    = pend_r;
    assign irq_req   = rst_pend | (|pend_r);

    // Pending sources and reset request
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            pend_r   <= '0;
            rst_pend <= 1'b0;
        end else begin
            pend_r <= (pend_r & ~clr_mask) | src_set;
            if (reset_req)   rst_pend <= 1'b1;
            else if (accept) rst_pend <= 1'b0;
        end
    end

    // Push datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ret_r    <= '0;
            sp_r     <= '0;
            vec_pc_r <= '0;
            bidx     <= '0;
            nbytes_r <= 2'd1;
        end else if (accept) begin
            ret_r    <= RET_W'(ret_pc);
            sp_r     <= sp_cur;
            vec_pc_r <= vec_pc;
            bidx     <= '0;
            nbytes_r <= nbytes_cfg;
        end else if (state == ST_PUSH) begin
            sp_r <= sp_r - SPW'(1);
            bidx <= bidx + 2'd1;
        end
    end
endmodule

// File: rtl/irq_entry_chk.sv
module irq_entry_chk #(
    parameter int NSRC = 8,
    parameter int SPW  = 16
) (
    input logic            clk,
    input logic            rst_n,
    input logic            busy,
    input logic            skip_pend,
    input logic            gie,
    input logic            mem_we,
    input logic [SPW-1:0]  mem_addr,
    input logic            pc_load,
    input logic            sp_load,
    input logic            gie_clr,
    input logic [NSRC-1:0] pend_q,
    input logic            irq_req
);
    a_r1_skip_blocks: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && skip_pend) |=> !busy);

    a_r2_gie_gates: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && !gie) |=> !busy);

    a_r6_addr_step: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_we && $past(mem_we)) |-> (mem_addr == $past(mem_addr) - SPW'(1)));

    a_r7_write_in_busy: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> busy);

    a_r8_load_bundle: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |-> (gie_clr && sp_load && busy && !mem_we));

    a_r8_load_ends: assert property (@(posedge clk) disable iff (!rst_n)
        pc_load |=> !busy);

    a_r9_req_tracks: assert property (@(posedge clk) disable iff (!rst_n)
        (|pend_q) |-> irq_req);
endmodule

bind irq_entry_seq irq_entry_chk #(.NSRC(NSRC), .SPW(SPW)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .skip_pend (skip_pend),
    .gie       (gie),
    .mem_we    (mem_we),
    .mem_addr  (mem_addr),
    .pc_load   (pc_load),
    .sp_load   (sp_load),
    .gie_clr   (gie_clr),
    .pend_q    (pend_q),
    .irq_req   (irq_req)
);

// File: tb/test_irq_entry_seq.sv
`timescale 1ns/1ps
module test_irq_entry_seq;
    localparam int NSRC = 8;
    localparam int PCW  = 22;
    localparam int SPW  = 16;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            reset_req = 1'b0;
    logic [NSRC-1:0] src_set = '0;
    logic            gie = 1'b0;
    logic            gie_set = 1'b0;
    logic            skip_pend = 1'b0;
    logic [1:0]      cfg_pc_bytes = 2'd2;
    logic            cfg_long_vec = 1'b0;
    logic [PCW-1:0]  ret_pc = '0;
    logic [SPW-1:0]  sp_cur = 16'h0800;
    logic            busy, irq_req, mem_we, pc_load, sp_load, gie_clr;
    logic [NSRC-1:0] pend_q;
    logic [SPW-1:0]  mem_addr, sp_next;
    logic [7:0]      mem_wdata;
    logic [PCW-1:0]  pc_new;

    int n_chk = 0;
    int n_bad = 0;
    bit finished = 1'b0;

    always #4 clk = ~clk;

    // Model of the core's enable flag
    always @(posedge clk) begin
        if (gie_clr)      gie <= 1'b0;
        else if (gie_set) gie <= 1'b1;
    end

    irq_entry_seq #(.NSRC(NSRC), .PCW(PCW), .SPW(SPW)) i_irq_entry_seq (
        .clk(clk), .rst_n(rst_n), .reset_req(reset_req), .src_set(src_set),
        .gie(gie), .skip_pend(skip_pend), .cfg_pc_bytes(cfg_pc_bytes),
        .cfg_long_vec(cfg_long_vec), .ret_pc(ret_pc), .sp_cur(sp_cur),
        .busy(busy), .irq_req(irq_req), .pend_q(pend_q), .mem_we(mem_we),
        .mem_addr(mem_addr), .mem_wdata(mem_wdata), .pc_load(pc_load),
        .pc_new(pc_new), .sp_load(sp_load), .sp_next(sp_next), .gie_clr(gie_clr)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    task automatic pulse_src(input logic [NSRC-1:0] m);
        @(negedge clk); src_set = m;
        @(negedge clk); src_set = '0;
    endtask

    task automatic pulse_reset_req();
        @(negedge clk); reset_req = 1'b1;
        @(negedge clk); reset_req = 1'b0;
    endtask

    task automatic enable_gie();
        @(negedge clk); gie_set = 1'b1;
        @(negedge clk); gie_set = 1'b0;
    endtask

    task automatic idle_cycles(input string req, input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            check(!busy && !mem_we, req, "busy while blocked", busy, 0);
        end
    endtask

    // Follows one entry sequence and checks stack bytes, sp, vector, length
    task automatic expect_entry(input string req, input int vec, input int nb);
        logic [23:0] ret = 24'(ret_pc);
        logic [SPW-1:0] sp0 = sp_cur;
        int k = 0;
        int bcyc = 0;
        int guard = 0;
        bit done = 1'b0;
        while (!done && guard < 40) begin
            @(negedge clk);
            guard++;
            if (busy) bcyc++;
            if (mem_we) begin
                check(mem_addr == sp0 - SPW'(k), "R6", "push address", mem_addr, sp0 - SPW'(k));
                check(mem_wdata == ret[8*k +: 8], "R6", "push byte", mem_wdata, ret[8*k +: 8]);
                k++;
            end
            if (pc_load) begin
                check(pc_new == PCW'(vec << cfg_long_vec), req, "vector pc (R5)",
                      pc_new, vec << cfg_long_vec);
                check(sp_load && sp_next == sp0 - SPW'(nb), "R6", "final sp",
                      sp_next, sp0 - SPW'(nb));
                check(gie_clr && !mem_we, "R8", "load bundle", gie_clr, 1);
                done = 1'b1;
            end
        end
        check(done, "R7", "sequence completed", done, 1);
        check(k == nb, "R7", "byte count", k, nb);
        check(bcyc == nb + 1, "R7", "busy length", bcyc, nb + 1);
        @(negedge clk);
        check(!busy && !gie, "R8", "idle and enable cleared", {busy, gie}, 0);
    endtask

    task automatic t_reset_state();
        check(!busy && !mem_we && !pc_load && !irq_req && pend_q == '0,
              "R7", "reset state", {busy, mem_we, pc_load, irq_req}, 0);
    endtask

    task automatic t_gie_off();
        pulse_src(8'h04);
        idle_cycles("R2", 6);
        check(irq_req && pend_q == 8'h04, "R2", "pending held", pend_q, 8'h04);
    endtask

    task automatic t_skip_then_take();
        @(negedge clk);
        skip_pend = 1'b1; cfg_pc_bytes = 2'd2; cfg_long_vec = 1'b1;
        ret_pc = 22'h2A_BCDE; sp_cur = 16'h08FF;
        enable_gie();
        idle_cycles("R1", 5);
        @(negedge clk); skip_pend = 1'b0;
        expect_entry("R4", 3, 2);
        check(pend_q == '0 && !irq_req, "R9", "serviced bit cleared", pend_q, 0);
    endtask

    task automatic t_multi_source();
        @(negedge clk);
        cfg_pc_bytes = 2'd3; cfg_long_vec = 1'b0;
        ret_pc = 22'h13_5791; sp_cur = 16'h0400;
        pulse_src(8'h12);
        enable_gie();
        expect_entry("R4", 2, 3);
        check(pend_q == 8'h10 && irq_req, "R9", "only lowest cleared", pend_q, 8'h10);
        @(negedge clk); cfg_pc_bytes = 2'd0; sp_cur = 16'h0300;
        enable_gie();
        expect_entry("R4", 5, 1);
        check(pend_q == '0, "R9", "second bit cleared", pend_q, 0);
    endtask

    task automatic t_reset_priority();
        @(negedge clk);
        cfg_pc_bytes = 2'd1; cfg_long_vec = 1'b1; ret_pc = 22'h00_0077; sp_cur = 16'h0200;
        skip_pend = 1'b1;
        pulse_src(8'h01);
        pulse_reset_req();
        enable_gie();
        idle_cycles("R1", 4);
        @(negedge clk); skip_pend = 1'b0;
        expect_entry("R3", 0, 1);
        check(pend_q == 8'h01 && irq_req, "R3", "source kept after reset entry", pend_q, 8'h01);
        enable_gie();
        expect_entry("R4", 1, 1);
    endtask

    task automatic t_arrival_during();
        @(negedge clk);
        cfg_pc_bytes = 2'd3; cfg_long_vec = 1'b1; ret_pc = 22'h3F_00A5; sp_cur = 16'h0700;
        pulse_src(8'h08);
        enable_gie();
        fork
            expect_entry("R10", 4, 3);
            begin
                @(negedge clk); @(negedge clk);
                src_set = 8'h40;
                @(negedge clk); src_set = '0;
            end
        join
        check(pend_q == 8'h40 && irq_req, "R10", "late bit kept", pend_q, 8'h40);
        @(negedge clk); sp_cur = 16'h06F0;
        enable_gie();
        expect_entry("R10", 7, 3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset_state();
        t_gie_off();
        t_skip_then_take();
        t_multi_source();
        t_reset_priority();
        t_arrival_during();
        if (!finished) begin
            finished = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        #(8 * 200000);
        if (!finished) begin
            finished = 1'b1;
            n_chk++;
            n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule